// File: doc/BRIEF.md
# Memory Module Geometry Decoder

This block turns per-socket module descriptor fields into the configuration words a memory controller needs. After a start pulse, software or a sequencer presents the descriptor of each DIMM socket in turn, one beat per socket. The block works out each module's page size and the capacity of each of its sides, and builds a running row-boundary map across the sockets. It also collects the banks-per-row flags and the overall memory-type code, and raises a sticky error flag for configurations it cannot support.

Each socket holds two rows. Boundaries are cumulative and counted in 8 MB units. Once the last socket has been taken, a one-cycle done strobe is given, and every output then holds its value until the next start. Reading the descriptor storage is the job of another block.

Top module: `dimm_geom_decoder`

## Requirements
- R1: The effective width is the data width minus the error-check width when the ECC flag is set, and the data width alone when it is clear (8-bit arithmetic). The page size in KB is (width << column bits) >> 13.
- R2: Page size code: 2 KB gives 00, 4 KB gives 01, 8 KB gives 10, and 16 KB or more is clamped to 10. Any other size on an installed module gives code 00 and sets the error flag.
- R3: Side 1 takes the highest set bit of the density byte. For a dual-sided module, side 2 takes the second-highest set bit, or equals side 1 when only one bit is set. Side 2 is 0 for a module that is not dual-sided (side count other than 2).
- R4: A density bit of value v stands for 4*v MB. Each side is capped at 128 MB and converted to 8 MB units.
- R5: Socket i drives row 2i and row 2i+1. bounds_o[8r+:8] for row r is the running total plus side 1 for row 2i, and that value plus side 2 for row 2i+1. An empty socket (type 00 or 11) repeats the running total in both rows.
- R6: page_word_o[4i+:4] holds socket i's rows. The low 2 bits are row 2i and the high 2 bits are row 2i+1. A dual-sided module puts its code in both fields, a single-sided one only in the low field, and an empty socket writes 0000.
- R7: bank_row_o[2i+:2] is 01 when socket i has 4 banks per device and is not dual-sided, 11 when it has 4 banks and is dual-sided, and 00 otherwise.
- R8: Socket type input: 01 is EDO and 10 is SDRAM. mem_type_o is 10 when SDRAM is present and every installed module is registered, 01 when SDRAM is present otherwise, and 00 otherwise.
- R9: err_o is set by any of these on an installed module: side 1 below 8 MB, a side count other than 1 or 2, or an invalid page size. It is also set when EDO and SDRAM modules are both installed. err_o stays set until the next start.
- R10: done_o pulses for one cycle, in the cycle after the fourth socket beat is taken. Socket beats outside a run are ignored, and all outputs hold until start_i.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears results and begins a run |
| sock_valid_i | input | 1 | Descriptor beat for the next socket |
| mem_type_i | input | 2 | 00/11 empty, 01 EDO, 10 SDRAM |
| col_bits_i | input | 4 | Column address bits |
| data_width_i | input | 8 | Module data width |
| ecc_width_i | input | 8 | Error-check width |
| ecc_i | input | 1 | Module carries ECC |
| registered_i | input | 1 | Module is registered |
| sides_i | input | 2 | Side count |
| dev_banks_i | input | 4 | Banks per device |
| density_i | input | 8 | Density bitmask |
| bounds_o | output | 64 | Eight row boundaries, 8 bits each |
| page_word_o | output | 16 | Packed 2-bit page codes per row |
| bank_row_o | output | 8 | Banks-per-row flags |
| mem_type_o | output | 2 | Memory-type code |
| err_o | output | 1 | Unsupported configuration |
| done_o | output | 1 | Run complete strobe |

## Verification
The hardest case to reach from the ports is a run that mixes conditions across sockets: asymmetric dual-sided modules, capped sides and empty sockets in between, so that the running total has to carry correctly through every row. Another is a run in which one module silently clears the all-registered property, or one EDO module poisons a run of SDRAM modules. Directed runs build these combinations. Weighted random runs then draw density masks with one or two bits, column counts around the page-size thresholds, and rare odd side counts. An extra beat after done and a beat before any start show that out-of-run input leaves the outputs untouched.

// File: rtl/dimm_geom_pkg.sv
package dimm_geom_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'b00, SLOT_EDO = 2'b01, SLOT_SDRAM = 2'b10, SLOT_VOID = 2'b11
  } slot_kind_e;

  typedef enum logic [1:0] {
    MT_EDO = 2'b00, MT_SDRAM = 2'b01, MT_REG_SDRAM = 2'b10
  } mem_kind_e;

  // capacity of one density bit position, capped, in boundary units
  function automatic int unsigned side_units(input int idx, input int unsigned mb_per_lsb,
                                             input int unsigned cap_mb, input int unsigned unit_mb);
    int unsigned mb;
    if (idx < 0) return 0;
    mb = mb_per_lsb << idx;
    if (mb > cap_mb) mb = cap_mb;
    return mb / unit_mb;
  endfunction
endpackage

// File: rtl/dimm_page_code.sv
module dimm_page_code #(
  parameter int COL_W    = 4,
  parameter int WID_W    = 8,
  parameter int KB_SHIFT = 13
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [WID_W-1:0] ecc_width_i,
  input  logic             ecc_i,
  output logic [1:0]       code_o,
  output logic             bad_o
);
  localparam int PROD_W = (1 << COL_W) + WID_W;
  localparam int KB_W   = PROD_W - KB_SHIFT;

  logic [WID_W-1:0]  weff;
  logic [PROD_W-1:0] prod;
  logic [KB_W-1:0]   kb;

  assign weff = ecc_i ? width_i - ecc_width_i : width_i;
  assign prod = {{(PROD_W-WID_W){1'b0}}, weff} << col_i;
  assign kb   = prod[PROD_W-1:KB_SHIFT];

  always_comb begin
    bad_o  = 1'b0;
    code_o = 2'b00;
    if (kb == KB_W'(2))       code_o = 2'b00;
    else if (kb == KB_W'(4))  code_o = 2'b01;
    else if (kb == KB_W'(8))  code_o = 2'b10;
    else if (kb >= KB_W'(16)) code_o = 2'b10;
    else                      bad_o  = 1'b1;
  end
endmodule

// File: rtl/dimm_density_split.sv
module dimm_density_split
  import dimm_geom_pkg::*;
#(
  parameter int DENS_W     = 8,
  parameter int UNIT_W     = 5,
  parameter int MB_PER_LSB = 4,
  parameter int CAP_MB     = 128,
  parameter int UNIT_MB    = 8
) (
  input  logic [DENS_W-1:0] density_i,
  input  logic              dual_i,
  output logic [UNIT_W-1:0] side1_o,
  output logic [UNIT_W-1:0] side2_o
);
  always_comb begin
    int hi;
    int lo;
    hi = -1;
    lo = -1;
    for (int b = 0; b < DENS_W; b++)
      if (density_i[b]) hi = b;
    for (int b = 0; b < DENS_W; b++)
      if (density_i[b] && b != hi) lo = b;
    side1_o = UNIT_W'(side_units(hi, MB_PER_LSB, CAP_MB, UNIT_MB));
    if (!dual_i)     side2_o = '0;
    else if (lo < 0) side2_o = side1_o;
    else             side2_o = UNIT_W'(side_units(lo, MB_PER_LSB, CAP_MB, UNIT_MB));
  end
endmodule

// File: rtl/dimm_geom_decoder.sv
module dimm_geom_decoder
  import dimm_geom_pkg::*;
#(
  parameter int NUM_SOCKETS = 4,
  parameter int BND_W       = 8,
  parameter int COL_W       = 4,
  parameter int WID_W       = 8,
  parameter int DENS_W      = 8,
  parameter int MB_PER_LSB  = 4,
  parameter int CAP_MB      = 128,
  parameter int UNIT_MB     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           sock_valid_i,
  input  logic [1:0]                     mem_type_i,
  input  logic [COL_W-1:0]               col_bits_i,
  input  logic [WID_W-1:0]               data_width_i,
  input  logic [WID_W-1:0]               ecc_width_i,
  input  logic                           ecc_i,
  input  logic                           registered_i,
  input  logic [1:0]                     sides_i,
  input  logic [3:0]                     dev_banks_i,
  input  logic [DENS_W-1:0]              density_i,
  output logic [2*NUM_SOCKETS*BND_W-1:0] bounds_o,
  output logic [4*NUM_SOCKETS-1:0]       page_word_o,
  output logic [2*NUM_SOCKETS-1:0]       bank_row_o,
  output logic [1:0]                     mem_type_o,
  output logic                           err_o,
  output logic                           done_o
);
  localparam int ROWS   = 2 * NUM_SOCKETS;
  localparam int IDX_W  = (NUM_SOCKETS > 1) ? $clog2(NUM_SOCKETS) : 1;
  localparam int UNIT_W = $clog2(CAP_MB / UNIT_MB + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SOCKETS - 1);

  logic [IDX_W-1:0]       idx_q;
  logic                   busy_q, done_q, err_q, edo_q, sd_q, allreg_q;
  logic [BND_W-1:0]       total_q;
  logic [ROWS*BND_W-1:0]  bounds_q;
  logic [4*NUM_SOCKETS-1:0] page_q;
  logic [ROWS-1:0]        bpr_q;

  logic             take, installed, is_edo, is_sd, dual, sides_bad, page_bad;
  logic [1:0]       pcode;
  logic [UNIT_W-1:0] s1_u, s2_u;
  logic [BND_W-1:0] row_a, row_b;
  logic [3:0]       pfield;
  logic [1:0]       bfield;
  logic             beat_err;

  assign take      = busy_q && sock_valid_i;
  assign is_edo    = mem_type_i == SLOT_EDO;
  assign is_sd     = mem_type_i == SLOT_SDRAM;
  assign installed = is_edo || is_sd;
  assign dual      = sides_i == 2'd2;
  assign sides_bad = !(sides_i == 2'd1 || sides_i == 2'd2);

  dimm_page_code #(.COL_W(COL_W), .WID_W(WID_W), .KB_SHIFT(13)) u_page (
    .col_i(col_bits_i), .width_i(data_width_i), .ecc_width_i(ecc_width_i),
    .ecc_i(ecc_i), .code_o(pcode), .bad_o(page_bad)
  );

  dimm_density_split #(
    .DENS_W(DENS_W), .UNIT_W(UNIT_W), .MB_PER_LSB(MB_PER_LSB),
    .CAP_MB(CAP_MB), .UNIT_MB(UNIT_MB)
  ) u_dens (
    .density_i(density_i), .dual_i(dual), .side1_o(s1_u), .side2_o(s2_u)
  );

  always_comb begin
    row_a    = total_q;
    row_b    = total_q;
    pfield   = 4'b0000;
    bfield   = 2'b00;
    beat_err = 1'b0;
    if (installed) begin
      row_a    = total_q + BND_W'(s1_u);
      row_b    = row_a + BND_W'(s2_u);
      pfield   = dual ? {pcode, pcode} : {2'b00, pcode};
      if (dev_banks_i == 4'd4) bfield = dual ? 2'b11 : 2'b01;
      beat_err = sides_bad || page_bad || (s1_u == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      edo_q <= 1'b0; sd_q <= 1'b0; allreg_q <= 1'b1; total_q <= '0;
      bounds_q <= '0; page_q <= '0; bpr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        idx_q <= '0; busy_q <= 1'b1; err_q <= 1'b0;
        edo_q <= 1'b0; sd_q <= 1'b0; allreg_q <= 1'b1; total_q <= '0;
        bounds_q <= '0; page_q <= '0; bpr_q <= '0;
      end else if (take) begin
        bounds_q[(2*int'(idx_q))*BND_W +: BND_W]   <= row_a;
        bounds_q[(2*int'(idx_q)+1)*BND_W +: BND_W] <= row_b;
        page_q[4*int'(idx_q) +: 4] <= pfield;
        bpr_q[2*int'(idx_q) +: 2]  <= bfield;
        total_q <= row_b;
        edo_q   <= edo_q || is_edo;
        sd_q    <= sd_q || is_sd;
        if (installed && !registered_i) allreg_q <= 1'b0;
        err_q <= err_q || beat_err || ((edo_q || is_edo) && (sd_q || is_sd));
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign bounds_o    = bounds_q;
  assign page_word_o = page_q;
  assign bank_row_o  = bpr_q;
  assign err_o       = err_q;
  assign done_o      = done_q;
  assign mem_type_o  = (sd_q && allreg_q) ? MT_REG_SDRAM : (sd_q ? MT_SDRAM : MT_EDO);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(bounds_o) && $stable(page_word_o)
                               && $stable(bank_row_o) && $stable(err_o)));
  p_side_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> (s2_u <= s1_u || !dual || s1_u == '0));
  p_total_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !start_i) |=> total_q >= $past(total_q));
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
  p_type_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_type_o != 2'b11);
endmodule

// File: tb/dimm_geom_decoder_test.sv
`timescale 1ns/1ps
module dimm_geom_decoder_test;
  localparam int NS = 4;

  typedef struct packed {
    logic [1:0] typ;
    logic [3:0] col;
    logic [7:0] wid;
    logic [7:0] eccw;
    logic       ecc;
    logic       regd;
    logic [1:0] sides;
    logic [3:0] banks;
    logic [7:0] dens;
  } sock_t;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, sock_valid_i = 0;
  logic [1:0] mem_type_i = 0;
  logic [3:0] col_bits_i = 0;
  logic [7:0] data_width_i = 0, ecc_width_i = 0;
  logic ecc_i = 0, registered_i = 0;
  logic [1:0] sides_i = 0;
  logic [3:0] dev_banks_i = 0;
  logic [7:0] density_i = 0;
  logic [63:0] bounds_o;
  logic [15:0] page_word_o;
  logic [7:0] bank_row_o;
  logic [1:0] mem_type_o;
  logic err_o, done_o;

  always #2 clk = ~clk;

  dimm_geom_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sock_valid_i(sock_valid_i),
    .mem_type_i(mem_type_i), .col_bits_i(col_bits_i), .data_width_i(data_width_i),
    .ecc_width_i(ecc_width_i), .ecc_i(ecc_i), .registered_i(registered_i),
    .sides_i(sides_i), .dev_banks_i(dev_banks_i), .density_i(density_i),
    .bounds_o(bounds_o), .page_word_o(page_word_o), .bank_row_o(bank_row_o),
    .mem_type_o(mem_type_o), .err_o(err_o), .done_o(done_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  sock_t cfg [NS];
  logic [63:0] e_bnd;
  logic [15:0] e_pg;
  logic [7:0]  e_bpr;
  logic [1:0]  e_typ;
  logic        e_err;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int units(input int h);
    int mb;
    if (h < 0) return 0;
    mb = 4 << h;
    if (mb > 128) mb = 128;
    return mb / 8;
  endfunction

  task automatic model();
    int total, hi, lo, s1, s2, kb;
    bit edo, sd, allreg, inst, dual, bad;
    logic [7:0] w;
    logic [1:0] code;
    longint bits;
    total = 0; edo = 0; sd = 0; allreg = 1;
    e_bnd = '0; e_pg = '0; e_bpr = '0; e_err = 0;
    for (int i = 0; i < NS; i++) begin
      inst = cfg[i].typ == 2'b01 || cfg[i].typ == 2'b10;
      if (!inst) begin
        e_bnd[16*i +: 8] = 8'(total);
        e_bnd[16*i+8 +: 8] = 8'(total);
        continue;
      end
      if (cfg[i].typ == 2'b01) edo = 1; else sd = 1;
      if (!cfg[i].regd) allreg = 0;
      dual = cfg[i].sides == 2;
      w = cfg[i].ecc ? cfg[i].wid - cfg[i].eccw : cfg[i].wid;      // R1
      bits = longint'(w) << cfg[i].col;
      kb = int'(bits >> 13);
      bad = 0;
      if (kb == 2) code = 0;                                         // R2
      else if (kb == 4) code = 1;
      else if (kb == 8 || kb >= 16) code = 2;
      else begin code = 0; bad = 1; end
      hi = -1; lo = -1;                                              // R3
      for (int b = 7; b >= 0; b--) if (cfg[i].dens[b]) begin
        if (hi < 0) hi = b; else if (lo < 0) lo = b;
      end
      s1 = units(hi);                                                // R4
      s2 = !dual ? 0 : (lo < 0 ? s1 : units(lo));
      if (bad || s1 == 0 || !(cfg[i].sides == 1 || dual)) e_err = 1;
      total += s1;
      e_bnd[16*i +: 8] = 8'(total);
      total += s2;
      e_bnd[16*i+8 +: 8] = 8'(total);
      e_pg[4*i +: 4] = dual ? {code, code} : {2'b00, code};
      if (cfg[i].banks == 4) e_bpr[2*i +: 2] = dual ? 2'b11 : 2'b01;
    end
    if (edo && sd) e_err = 1;
    e_typ = (sd && allreg) ? 2'b10 : (sd ? 2'b01 : 2'b00);
  endtask

  task automatic drive(input sock_t s, input bit v);
    sock_valid_i = v; mem_type_i = s.typ; col_bits_i = s.col; data_width_i = s.wid;
    ecc_width_i = s.eccw; ecc_i = s.ecc; registered_i = s.regd; sides_i = s.sides;
    dev_banks_i = s.banks; density_i = s.dens;
  endtask

  task automatic run(input bit gaps);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < NS; i++) begin
      if (gaps && ($urandom % 2) == 1) begin
        drive(cfg[i], 0);
        @(negedge clk);
      end
      drive(cfg[i], 1);
      @(negedge clk);
      if (i == NS - 2) check("R10 no early done", done_o, 0);
    end
    drive(cfg[0], 0);
    model();
    check("R10 done strobe", done_o, 1);
    check("R5 R3 R4 boundaries", bounds_o, e_bnd);
    check("R6 R1 R2 page word", page_word_o, e_pg);
    check("R7 banks per row", bank_row_o, e_bpr);
    check("R8 memory type", mem_type_o, e_typ);
    check("R9 error flag", err_o, e_err);
    @(negedge clk);
    check("R10 done one cycle", done_o, 0);
  endtask

  function automatic sock_t sd_mod(input logic [7:0] dens, input logic [1:0] sides,
                                   input logic [3:0] col, input logic [7:0] wid);
    sock_t s;
    s = '0; s.typ = 2'b10; s.col = col; s.wid = wid; s.sides = sides;
    s.banks = 4; s.dens = dens; s.regd = 1;
    return s;
  endfunction

  task automatic all_empty();
    for (int i = 0; i < NS; i++) cfg[i] = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1029));
    repeat (3) @(negedge clk);
    check("R11 reset bounds", bounds_o, 0);
    check("R11 reset page", {page_word_o, bank_row_o, mem_type_o, err_o, done_o}, 0);
    rst_ni = 1;
    // R10: beat outside a run is ignored
    drive(sd_mod(8'h10, 1, 9, 64), 1);
    @(negedge clk); @(negedge clk);
    drive(sd_mod(8'h10, 1, 9, 64), 0);
    check("R10 ignored beat bounds", bounds_o, 0);
    check("R10 ignored beat done", done_o, 0);

    all_empty(); run(0);                                              // R5 empty sockets
    all_empty(); cfg[0] = sd_mod(8'h10, 1, 9, 64); run(0);            // 64MB single, 4KB
    all_empty(); cfg[1] = sd_mod(8'h30, 2, 10, 64); cfg[3] = sd_mod(8'h08, 2, 11, 64);
    run(0);                                                           // R3 asym + symmetric dual, R2 clamp
    all_empty(); cfg[0] = sd_mod(8'h80, 2, 8, 64); cfg[2] = sd_mod(8'hc0, 2, 8, 64);
    run(0);                                                           // R4 cap
    all_empty(); cfg[0] = sd_mod(8'h10, 1, 10, 72); cfg[0].ecc = 1; cfg[0].eccw = 8;
    cfg[1] = sd_mod(8'h10, 1, 10, 72); run(0);                        // R1 ECC subtract vs none
    all_empty(); cfg[0] = sd_mod(8'h10, 3, 9, 64); run(0);            // R9 bad side count
    all_empty(); cfg[0] = sd_mod(8'h01, 1, 9, 64); run(0);            // R9 side1 < 8MB
    all_empty(); cfg[0] = sd_mod(8'h10, 1, 8, 32); run(0);            // R2 1KB invalid
    all_empty(); cfg[0] = sd_mod(8'h10, 1, 9, 64); cfg[2] = sd_mod(8'h10, 1, 9, 64);
    cfg[2].typ = 2'b01; run(0);                                       // R9 mixed EDO/SDRAM
    all_empty(); cfg[0] = sd_mod(8'h10, 1, 9, 64); cfg[1] = sd_mod(8'h20, 2, 9, 64);
    cfg[1].regd = 0; cfg[1].banks = 2; run(0);                        // R8 unregistered, R7
    all_empty(); cfg[3] = sd_mod(8'h10, 1, 9, 64); cfg[3].typ = 2'b01; run(0); // R8 EDO only
    // R10 hold after done
    drive(sd_mod(8'h40, 2, 9, 64), 1);
    repeat (3) @(negedge clk);
    drive(cfg[0], 0);
    check("R10 hold bounds", bounds_o, e_bnd);
    check("R10 hold err", {page_word_o, err_o}, {e_pg, e_err});

    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < NS; i++) begin
        int r;
        sock_t s;
        r = $urandom % 10;
        s.typ = (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : (r == 2 && t % 3 == 0) ? 2'b01 : 2'b10;
        s.col = 4'(8 + $urandom % 4);
        s.wid = ($urandom % 2) ? 8'd72 : 8'd64;
        s.ecc = $urandom % 2;
        s.eccw = s.ecc ? 8'd8 : 8'($urandom % 9);
        s.regd = ($urandom % 4) != 0;
        r = $urandom % 20;
        s.sides = (r == 0) ? 2'd0 : (r == 1) ? 2'd3 : 2'(1 + $urandom % 2);
        s.banks = ($urandom % 2) ? 4'd4 : 4'd2;
        s.dens = 8'(1 << ($urandom % 8));
        if ($urandom % 2) s.dens = s.dens | 8'(1 << ($urandom % 8));
        cfg[i] = s;
      end
      run(1);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule